// File: doc/BRIEF.md
# Graphics Aperture Page Translator

This block maps addresses that land in a graphics aperture window onto physical system-memory addresses. It looks up a page table in memory that holds one 32-bit entry for each 4 KB page. Software sets three registers through a simple write port: the aperture base, the table base and size, and a control word. Each request then gets exactly one response. That response is one of four kinds: a pass-through, a range fault, an invalid-entry fault, or a translated address.

An eight-slot fully associative cache holds recently used entries so that a page seen before needs no memory read. On a cache miss the block issues one read on a memory port whose byte order is the reverse of the entries' storage order. It reorders the returned word, checks the entry's valid flag, and caches the entry only when that flag is set. The control word turns translation on and off. Any control write that carries the invalidate bit or the reset-strobe bit empties the cache. The documented four-write enable and disable sequences are built from these control writes.

Top module: `aperture_xlate`

## Requirements
- R1: The window check compares only request address bits [31:28] with bits [31:28] of the aperture base register (register select 0). Bits [27:0] of that register are ignored.
- R2: When translation is disabled, or when address bits [31:28] differ from the aperture base, the response comes one cycle after acceptance. It carries rsp_addr equal to the request address and rsp_window_miss high, and the block makes no memory read.
- R3: The page index is request address bits [27:12], which equals (address − aperture base) >> 12. If the index is at or above the table size, the response comes one cycle after acceptance with rsp_range_fault high and rsp_addr zero, and the block makes no memory read. The table size is held in bits [11:0] of the table register (select 1).
- R4: A cache miss issues exactly one memory read. Its address is (table register bits [31:12] << 12) + index × 4, and the address stays stable until mem_rd_valid.
- R5: The fetched word is byte-reversed before use: mem_rd_data bits [7:0] become entry bits [31:24], and so on for the other bytes.
- R6: An entry whose bit 0 is 0 gives rsp_fault high with rsp_addr zero, and it is not cached: a repeated request reads memory again.
- R7: A valid entry gives rsp_addr = {entry[31:12], request[11:0]}. Entry bits [11:1] are ignored.
- R8: A request whose index is held in the cache responds one cycle after acceptance with the cached translation, and the block makes no memory read.
- R9: The cache holds 8 entries and replaces them in round-robin order. The ninth valid fill evicts the oldest fill.
- R10: In the control register (select 2), bit 8 is the translation enable. A control write with bit 0 (invalidate) or bit 16 (reset strobe) set empties the cache. This applies both to the four-write enable sequence (0x101, 0x100, 0x10100, 0x100) and to the four-write disable sequence (0x101, 0, 0x10000, 0).
- R11: While a memory read is outstanding, idle, cfg_ready and req_ready are all low, so register writes (including the disable sequence) are accepted only while the block is idle.
- R12: A miss response appears on the cycle after the clock edge at which mem_rd_valid is sampled high, and mem_rd_req drops at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 aperture, 1 table, 2 control |
| cfg_wdata | input | 32 | Register write data |
| cfg_ready | output | 1 | Register write accepted this cycle |
| idle | output | 1 | Status: no memory read outstanding |
| req_valid | input | 1 | Translation request valid |
| req_addr | input | 32 | Bus address to translate |
| req_ready | output | 1 | Request accepted this cycle |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_addr | output | 32 | Translated or passed-through address |
| rsp_window_miss | output | 1 | Request was passed through untranslated |
| rsp_range_fault | output | 1 | Index beyond table size |
| rsp_fault | output | 1 | Entry valid bit clear |
| mem_rd_req | output | 1 | Table read request, held until data returns |
| mem_rd_addr | output | 32 | Table entry address |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Read data, byte order reversed from the entry |

## Verification
Pass-through, range-fault and cache-hit responses are due on the first falling edge after the accepting rising edge. A miss response is due one cycle after the memory returns data, which is three cycles after acceptance with the bench memory's two-cycle latency. The bench counts falling edges from acceptance and checks on every one of them that rsp_valid is low before the due cycle and high on it. While a fetch is outstanding it also checks that the block reports busy. The fetch count and fetch address are compared after each response.

// File: rtl/aperture_xlate.sv
module aperture_xlate #(
  parameter int AW    = 32,
  parameter int SLOTS = 8,
  parameter int PG    = 12,
  parameter int SZW   = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic          cfg_ready,
  output logic          idle,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  output logic          req_ready,
  output logic          rsp_valid,
  output logic [AW-1:0] rsp_addr,
  output logic          rsp_window_miss,
  output logic          rsp_range_fault,
  output logic          rsp_fault,
  output logic          mem_rd_req,
  output logic [AW-1:0] mem_rd_addr,
  input  logic          mem_rd_valid,
  input  logic [AW-1:0] mem_rd_data
);
  localparam int IDXW = AW - 4 - PG;
  localparam int PFNW = AW - PG;
  localparam int PW   = $clog2(SLOTS);
  localparam int NB   = AW / 8;

  logic [3:0]      ap_hi;
  logic [PFNW-1:0] tb_pfn;
  logic [SZW-1:0]  tb_size;
  logic            en;
  logic            busy;
  logic [PG-1:0]   pend_off;
  logic [IDXW-1:0] pend_idx;

  logic [SLOTS-1:0] slot_v;
  logic [IDXW-1:0]  slot_tag [SLOTS];
  logic [PFNW-1:0]  slot_pfn [SLOTS];
  logic [PW-1:0]    rr;

  assign idle       = !busy;
  assign cfg_ready  = !busy;
  assign req_ready  = !busy;
  assign mem_rd_req = busy;

  wire [IDXW-1:0] idx    = req_addr[AW-5:PG];
  wire            in_win = en && (req_addr[AW-1 -: 4] == ap_hi);
  wire            out_rng = idx >= {{(IDXW-SZW){1'b0}}, tb_size};
  wire            accept = req_valid && !busy;
  wire            flush  = cfg_wr && !busy && (cfg_sel == 2'd2) &&
                           (cfg_wdata[0] || cfg_wdata[16]);

  logic            hit;
  logic [PFNW-1:0] hit_pfn;
  always_comb begin
    hit = 1'b0;
    hit_pfn = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (slot_v[s] && slot_tag[s] == idx) begin
        hit = 1'b1;
        hit_pfn = hit_pfn | slot_pfn[s];
      end
    end
  end

  logic [AW-1:0] ent;
  for (genvar b = 0; b < NB; b++) begin : g_swap
    assign ent[8*b +: 8] = mem_rd_data[AW-8-8*b +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ap_hi   <= '0;
      tb_pfn  <= '0;
      tb_size <= '0;
      en      <= 1'b0;
    end else if (cfg_wr && !busy) begin
      case (cfg_sel)
        2'd0: ap_hi <= cfg_wdata[AW-1 -: 4];
        2'd1: begin
          tb_pfn  <= cfg_wdata[AW-1:PG];
          tb_size <= cfg_wdata[SZW-1:0];
        end
        2'd2: en <= cfg_wdata[8];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_v <= '0;
      rr     <= '0;
      for (int s = 0; s < SLOTS; s++) begin
        slot_tag[s] <= '0;
        slot_pfn[s] <= '0;
      end
    end else if (flush) begin
      slot_v <= '0;
    end else if (busy && mem_rd_valid && ent[0]) begin
      slot_v[rr]   <= 1'b1;
      slot_tag[rr] <= pend_idx;
      slot_pfn[rr] <= ent[AW-1:PG];
      rr           <= rr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy            <= 1'b0;
      pend_off        <= '0;
      pend_idx        <= '0;
      mem_rd_addr     <= '0;
      rsp_valid       <= 1'b0;
      rsp_addr        <= '0;
      rsp_window_miss <= 1'b0;
      rsp_range_fault <= 1'b0;
      rsp_fault       <= 1'b0;
    end else begin
      rsp_valid       <= 1'b0;
      rsp_window_miss <= 1'b0;
      rsp_range_fault <= 1'b0;
      rsp_fault       <= 1'b0;
      if (busy) begin
        if (mem_rd_valid) begin
          busy      <= 1'b0;
          rsp_valid <= 1'b1;
          if (ent[0]) begin
            rsp_addr <= {ent[AW-1:PG], pend_off};
          end else begin
            rsp_addr  <= '0;
            rsp_fault <= 1'b1;
          end
        end
      end else if (accept) begin
        if (!in_win) begin
          rsp_valid       <= 1'b1;
          rsp_addr        <= req_addr;
          rsp_window_miss <= 1'b1;
        end else if (out_rng) begin
          rsp_valid       <= 1'b1;
          rsp_addr        <= '0;
          rsp_range_fault <= 1'b1;
        end else if (hit) begin
          rsp_valid <= 1'b1;
          rsp_addr  <= {hit_pfn, req_addr[PG-1:0]};
        end else begin
          busy        <= 1'b1;
          pend_off    <= req_addr[PG-1:0];
          pend_idx    <= idx;
          mem_rd_addr <= {tb_pfn, {PG{1'b0}}} + AW'({idx, 2'b00});
        end
      end
    end
  end
endmodule

module aperture_xlate_chk #(
  parameter int AW    = 32,
  parameter int SLOTS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic [1:0]       cfg_sel,
  input logic [AW-1:0]    cfg_wdata,
  input logic             cfg_ready,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_window_miss,
  input logic             rsp_range_fault,
  input logic             rsp_fault,
  input logic             mem_rd_req,
  input logic [AW-1:0]    mem_rd_addr,
  input logic             mem_rd_valid,
  input logic [SLOTS-1:0] slot_v
);
  assert_fetch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));

  assert_busy_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> (!cfg_ready && !req_ready));

  assert_miss_resp_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && mem_rd_valid) |=> (rsp_valid && !mem_rd_req));

  assert_one_kind_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot0({rsp_window_miss, rsp_range_fault, rsp_fault}));

  assert_flags_only_resp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_window_miss || rsp_range_fault || rsp_fault));

  assert_flush_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_ready && cfg_sel == 2'd2 && (cfg_wdata[0] || cfg_wdata[16]))
    |=> (slot_v == '0));
endmodule

bind aperture_xlate aperture_xlate_chk #(.AW(AW), .SLOTS(SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
  .cfg_wdata(cfg_wdata), .cfg_ready(cfg_ready), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_window_miss(rsp_window_miss),
  .rsp_range_fault(rsp_range_fault), .rsp_fault(rsp_fault),
  .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
  .mem_rd_valid(mem_rd_valid), .slot_v(slot_v)
);

// File: tb/tb_aperture_xlate.sv
module tb_aperture_xlate;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_LAT = 2;
  localparam logic [31:0] TBASE = 32'h0040_0000;
  localparam int TSIZE = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        cfg_ready, idle, req_ready;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, rsp_window_miss, rsp_range_fault, rsp_fault;
  logic [31:0] rsp_addr;
  logic        mem_rd_req;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_valid = 1'b0;
  logic [31:0] mem_rd_data = '0;

  int checks = 0, errors = 0, fetches = 0, last_kind = 0;
  logic [31:0] last_fetch = '0;
  bit done = 0;

  int m_en = 0, m_ap = 0, m_tpfn = 0, m_tsize = 0, mrr = 0;
  int mt[8];
  bit mv[8];

  aperture_xlate dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_ready(cfg_ready), .idle(idle),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
    .rsp_window_miss(rsp_window_miss), .rsp_range_fault(rsp_range_fault),
    .rsp_fault(rsp_fault), .mem_rd_req(mem_rd_req),
    .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
    .mem_rd_data(mem_rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] entry(int i);
    logic [19:0] pfn = 20'(32'h300 + i * 7);
    return {pfn, 11'h5a, 1'(i % 5 != 4)};
  endfunction

  function automatic logic [31:0] bswap(logic [31:0] e);
    return {e[7:0], e[15:8], e[23:16], e[31:24]};
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  int wait_c = 0;
  always @(negedge clk) begin
    if (mem_rd_valid) begin
      mem_rd_valid = 1'b0;
    end else if (mem_rd_req) begin
      if (wait_c == MEM_LAT - 1) begin
        wait_c = 0;
        fetches++;
        last_fetch = mem_rd_addr;
        mem_rd_data = bswap(entry(int'((mem_rd_addr - TBASE) >> 2)));
        mem_rd_valid = 1'b1;
      end else begin
        wait_c++;
      end
    end
  end

  task automatic cfg(logic [1:0] sel, logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    case (sel)
      2'd0: m_ap = int'(d[31:28]);
      2'd1: begin m_tpfn = int'(d[31:12]); m_tsize = int'(d[11:0]); end
      2'd2: begin
        m_en = int'(d[8]);
        if (d[0] || d[16]) for (int s = 0; s < 8; s++) mv[s] = 0;
      end
      default: ;
    endcase
  endtask

  task automatic xlate(logic [31:0] a, string tag);
    int kind, idx, lat, f0, slot;
    logic [31:0] ea, e;
    bit ew, ef, er;
    idx = int'(a[27:12]);
    ew = 0; ef = 0; er = 0; slot = -1; e = entry(idx);
    if (m_en == 0 || int'(a[31:28]) != m_ap) begin
      kind = 0; ea = a; ew = 1;
    end else if (idx >= m_tsize) begin
      kind = 1; ea = 0; er = 1;
    end else begin
      for (int s = 0; s < 8; s++) if (mv[s] && mt[s] == idx) slot = s;
      if (slot >= 0) begin
        kind = 2; ea = {e[31:12], a[11:0]};
      end else begin
        kind = 3;
        if (e[0]) ea = {e[31:12], a[11:0]};
        else begin ea = 0; ef = 1; end
      end
    end
    lat = (kind == 3) ? MEM_LAT + 1 : 1;
    f0 = fetches;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    for (int n = 1; n <= lat; n++) begin
      check(rsp_valid == (n == lat), {tag, " R12 response timing"}, 32'(rsp_valid), 32'(n == lat));
      if (kind == 3 && n < lat)
        check(!idle && !cfg_ready && !req_ready, {tag, " R11 busy during fetch"},
              {idle, cfg_ready, req_ready}, 32'h0);
      if (n == lat) begin
        check(rsp_addr == ea, {tag, " address"}, rsp_addr, ea);
        check({rsp_window_miss, rsp_range_fault, rsp_fault} == {ew, er, ef},
              {tag, " flags"}, {rsp_window_miss, rsp_range_fault, rsp_fault}, {ew, er, ef});
      end else begin
        @(negedge clk);
      end
    end
    if (kind == 3) begin
      check(fetches == f0 + 1, {tag, " R4 one fetch"}, fetches - f0, 1);
      check(last_fetch == TBASE + 32'(idx * 4), {tag, " R4 fetch address"},
            last_fetch, TBASE + 32'(idx * 4));
      if (e[0]) begin mt[mrr] = idx; mv[mrr] = 1; mrr = (mrr + 1) % 8; end
    end else begin
      check(fetches == f0, {tag, " no fetch"}, fetches - f0, 0);
    end
    last_kind = kind;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 8; s++) begin mt[s] = 0; mv[s] = 0; end
    repeat (3) @(negedge clk);
    check(!rsp_valid && req_ready && idle && cfg_ready && !mem_rd_req, "reset state",
          {rsp_valid, req_ready, idle, cfg_ready, mem_rd_req}, 32'b01110);
    rst_n = 1'b1;
    cfg(2'd0, 32'h8123_4567);
    cfg(2'd1, TBASE | TSIZE);
    xlate(32'h8000_1234, "R2 disabled");
    cfg(2'd2, 32'h101); cfg(2'd2, 32'h100); cfg(2'd2, 32'h10100); cfg(2'd2, 32'h100);
    xlate(32'h9000_0000, "R2 outside window");
    xlate(32'h8000_0abc, "R1 R5 R7 first miss");
    check(last_kind == 3, "R1 low base bits ignored", last_kind, 3);
    xlate(32'h8000_0def, "R8 hit");
    check(last_kind == 2, "R8 kind", last_kind, 2);
    xlate(32'h8000_4010, "R6 invalid");
    xlate(32'h8000_4020, "R6 invalid again");
    check(last_kind == 3, "R6 not cached", last_kind, 3);
    xlate(32'h8002_8000, "R3 index equals size");
    xlate(32'h8fff_f000, "R3 far index");
    xlate(32'h8002_7fff, "R3 last index");
    for (int i = 1; i <= 8; i++) if (i != 4) xlate(32'h8000_0000 | 32'(i << 12) | 32'h44, "R9 fill");
    xlate(32'h8000_a044, "R9 ninth fill");
    xlate(32'h8000_0100, "R9 evicted oldest");
    check(last_kind == 3, "R9 oldest refetched", last_kind, 3);
    xlate(32'h8000_2100, "R9 kept");
    check(last_kind == 2, "R9 survivor hit", last_kind, 2);
    cfg(2'd2, 32'h10100);
    xlate(32'h8000_2200, "R10 after strobe");
    check(last_kind == 3, "R10 strobe flushed", last_kind, 3);
    cfg(2'd2, 32'h100);
    xlate(32'h8000_2300, "R10 refilled hit");
    cfg(2'd2, 32'h101); cfg(2'd2, 32'h0); cfg(2'd2, 32'h10000); cfg(2'd2, 32'h0);
    xlate(32'h8000_2300, "R10 disabled pass");
    cfg(2'd2, 32'h100);
    xlate(32'h8000_2300, "R10 empty after disable seq");
    check(last_kind == 3, "R10 disable seq flushed", last_kind, 3);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule